// File: doc/BRIEF.md
# DRAM Row Boundary Address Decoder

This block turns a physical address into a DRAM row (chip select) choice for a memory controller that has eight rows. Software programs one 8-bit boundary register per row through a small byte-addressed configuration port. Each register gives the cumulative upper limit of its row in units of 8 MB. A row therefore starts where the row before it ends. A row whose limit repeats the previous limit holds no memory. A zero written after a nonzero limit means a 2 GB top.

Each lookup presents an address with a valid strobe. After one clock edge the block returns four results: a one-hot row select, the row index, a hit flag, and the byte offset of the address inside its row. If no row holds the address, for example when it lies at or above the top of populated memory, an out-of-range flag is raised instead. The decode itself is combinational and is followed by a single output register.

Top module: `dram_row_decoder`

## Requirements
- R1: After reset every boundary register reads 0 on `cfg_rdata`, `rs_valid` is 0, and every lookup reports out-of-range, because every row is empty.
- R2: When `cfg_we` is high at a clock edge, `cfg_wdata` is stored in the boundary register of row `cfg_addr` (addresses 0 to 7 select rows 0 to 7). `cfg_rdata` always shows the register selected by `cfg_addr`.
- R3: A row's limit in bytes is its register value times 2^23. Its base is the effective limit of the row before it, and row 0 has base 0. An address A with base <= A < limit decodes to that row with `rs_offset` = A - base.
- R4: A row whose effective limit equals the previous row's effective limit is empty and is never selected.
- R5: A register value of 0 whose previous effective limit is nonzero means a limit of 2^31, so that row covers every address up to 0x7FFF_FFFF. A 0 whose previous limit is 0, or a 0 after a 2 GB limit, gives an empty row.
- R6: When more than one row's window contains the address, which can happen with non-increasing values, the lowest-numbered row wins.
- R7: When no row contains the address, the outputs are `rs_oor`=1, `rs_hit`=0, `rs_sel`=0, `rs_row`=0 and `rs_offset`=0.
- R8: A lookup with `lk_valid` high at clock edge k gives `rs_valid`=1 and its results right after edge k. After an edge with `lk_valid` low, `rs_valid` is 0 and the result fields keep their previous values.
- R9: A lookup at the same edge as a boundary write is decoded with the boundaries as they were before that write.
- R10: On a hit, `rs_sel` is one-hot with bit `rs_row` set, and `rs_hit` and `rs_oor` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cfg_we | input | 1 | Boundary register write strobe |
| cfg_addr | input | 3 | Boundary register offset (row number) |
| cfg_wdata | input | 8 | Boundary value to write, in 8 MB units |
| cfg_rdata | output | 8 | Boundary register at `cfg_addr` |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 31 | Physical address to decode |
| rs_valid | output | 1 | Registered result is for a lookup made at the last edge |
| rs_sel | output | 8 | One-hot row select |
| rs_row | output | 3 | Selected row index |
| rs_hit | output | 1 | Address falls inside a populated row |
| rs_oor | output | 1 | Address falls inside no row |
| rs_offset | output | 31 | Address minus base of the selected row |

## Verification
A boundary write and a lookup can land on the same clock edge. This matters because the decode reads the stored registers while the write updates them. The bench programs a layout in which row 6 ends at 2 GB. At one edge it presents an address inside row 6 and, at the same edge, rewrites row 6's limit to 512 MB. That result must still report row 6. The next lookup of the same address must then land in row 7, whose stored zero now follows a nonzero limit and so means 2 GB. A third lookup, after row 7 is also set to 512 MB, must come back out-of-range.

// File: rtl/dram_row_pkg.sv
package dram_row_pkg;
    localparam int ROWS       = 8;
    localparam int BND_W      = 8;
    localparam int UNIT_SHIFT = 23;
    localparam int ADDR_W     = 31;
    localparam int LIM_W      = ADDR_W + 1;
    localparam int IDX_W      = $clog2(ROWS);

    typedef struct packed {
        logic              vld;
        logic [ROWS-1:0]   sel;
        logic [IDX_W-1:0]  row;
        logic              hit;
        logic              oor;
        logic [ADDR_W-1:0] off;
    } rsp_t;
endpackage

// File: rtl/drb_bank.sv
module drb_bank #(
    parameter int ROWS  = 8,
    parameter int BND_W = 8,
    parameter int AW    = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [BND_W-1:0]      wr_data,
    input  logic [AW-1:0]         rd_addr,
    output logic [BND_W-1:0]      rd_data,
    output logic [ROWS*BND_W-1:0] bnd_flat
);
    logic [BND_W-1:0] bnd_d [ROWS];
    logic [BND_W-1:0] bnd_q [ROWS];

    always_comb begin
        bnd_d = bnd_q;
        if (wr_en && (32'(wr_addr) < ROWS)) begin
            bnd_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ROWS; i++) bnd_q[i] <= '0;
        end else begin
            bnd_q <= bnd_d;
        end
    end

    assign rd_data = (32'(rd_addr) < ROWS) ? bnd_q[rd_addr] : '0;

    for (genvar g = 0; g < ROWS; g++) begin : g_flat
        assign bnd_flat[g*BND_W +: BND_W] = bnd_q[g];
    end
endmodule

// File: rtl/row_window.sv
module row_window #(
    parameter int BND_W      = 8,
    parameter int UNIT_SHIFT = 23,
    parameter int ADDR_W     = 31
) (
    input  logic [BND_W-1:0]  bnd,
    input  logic [ADDR_W:0]   prev_lim,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W:0]   lim,
    output logic              match,
    output logic [ADDR_W-1:0] offset
);
    localparam int LIM_W = ADDR_W + 1;
    localparam logic [LIM_W-1:0] TOP_LIM = LIM_W'(1) << ADDR_W;

    logic [LIM_W-1:0] scaled;
    logic [LIM_W-1:0] addr_w;
    logic [LIM_W-1:0] diff;

    always_comb begin
        scaled = LIM_W'(bnd) << UNIT_SHIFT;
        // zero after a populated limit marks the full top
        if ((bnd == '0) && (prev_lim != '0)) lim = TOP_LIM;
        else                                  lim = scaled;
        addr_w = {1'b0, addr};
        match  = (addr_w >= prev_lim) && (addr_w < lim);
        diff   = addr_w - prev_lim;
        offset = diff[ADDR_W-1:0];
    end
endmodule

// File: rtl/row_pick.sv
module row_pick #(
    parameter int ROWS   = 8,
    parameter int ADDR_W = 31,
    parameter int IDX_W  = 3
) (
    input  logic [ROWS-1:0]        match,
    input  logic [ROWS*ADDR_W-1:0] off_flat,
    output logic [ROWS-1:0]        sel,
    output logic [IDX_W-1:0]       idx,
    output logic                   hit,
    output logic [ADDR_W-1:0]      off
);
    always_comb begin
        sel = '0;
        idx = '0;
        hit = 1'b0;
        off = '0;
        // walk downward so the lowest matching row is the last to write
        for (int i = ROWS - 1; i >= 0; i--) begin
            if (match[i]) begin
                sel    = '0;
                sel[i] = 1'b1;
                idx    = IDX_W'(i);
                hit    = 1'b1;
                off    = off_flat[i*ADDR_W +: ADDR_W];
            end
        end
    end
endmodule

// File: rtl/dram_row_decoder.sv
module dram_row_decoder
    import dram_row_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_addr,
    input  logic [BND_W-1:0]  cfg_wdata,
    output logic [BND_W-1:0]  cfg_rdata,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              rs_valid,
    output logic [ROWS-1:0]   rs_sel,
    output logic [IDX_W-1:0]  rs_row,
    output logic              rs_hit,
    output logic              rs_oor,
    output logic [ADDR_W-1:0] rs_offset
);
    logic [ROWS*BND_W-1:0]  bnd_flat;
    logic [LIM_W-1:0]       lim_chain [ROWS+1];
    logic [ROWS-1:0]        row_match;
    logic [ROWS*ADDR_W-1:0] row_off;
    logic [ROWS-1:0]        pick_sel;
    logic [IDX_W-1:0]       pick_idx;
    logic                   pick_hit;
    logic [ADDR_W-1:0]      pick_off;
    rsp_t                   rsp_d, rsp_q;

    drb_bank #(.ROWS(ROWS), .BND_W(BND_W), .AW(IDX_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_addr  (cfg_addr),
        .wr_data  (cfg_wdata),
        .rd_addr  (cfg_addr),
        .rd_data  (cfg_rdata),
        .bnd_flat (bnd_flat)
    );

    assign lim_chain[0] = '0;

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        row_window #(.BND_W(BND_W), .UNIT_SHIFT(UNIT_SHIFT), .ADDR_W(ADDR_W)) u_win (
            .bnd      (bnd_flat[g*BND_W +: BND_W]),
            .prev_lim (lim_chain[g]),
            .addr     (lk_addr),
            .lim      (lim_chain[g+1]),
            .match    (row_match[g]),
            .offset   (row_off[g*ADDR_W +: ADDR_W])
        );
    end

    row_pick #(.ROWS(ROWS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_pick (
        .match    (row_match),
        .off_flat (row_off),
        .sel      (pick_sel),
        .idx      (pick_idx),
        .hit      (pick_hit),
        .off      (pick_off)
    );

    always_comb begin
        rsp_d     = rsp_q;
        rsp_d.vld = lk_valid;
        if (lk_valid) begin
            rsp_d.sel = pick_sel;
            rsp_d.row = pick_idx;
            rsp_d.hit = pick_hit;
            rsp_d.oor = ~pick_hit;
            rsp_d.off = pick_off;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rs_valid  = rsp_q.vld;
    assign rs_sel    = rsp_q.sel;
    assign rs_row    = rsp_q.row;
    assign rs_hit    = rsp_q.hit;
    assign rs_oor    = rsp_q.oor;
    assign rs_offset = rsp_q.off;
endmodule

// File: rtl/dram_row_decoder_chk.sv
module dram_row_decoder_chk
    import dram_row_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              rs_valid,
    input logic [ROWS-1:0]   rs_sel,
    input logic [IDX_W-1:0]  rs_row,
    input logic              rs_hit,
    input logic              rs_oor,
    input logic [ADDR_W-1:0] rs_offset
);
    // R8
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rs_valid);

    // R8
    vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rs_valid);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> ($stable(rs_sel) && $stable(rs_row) && $stable(rs_offset)));

    // R10
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rs_sel));

    // R10
    sel_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_hit) |-> (rs_sel == (ROWS'(1) << rs_row)));

    // R10
    hit_oor_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |-> (rs_hit != rs_oor));

    // R7
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_oor) |-> (rs_sel == '0 && rs_row == '0 && rs_offset == '0));
endmodule

bind dram_row_decoder dram_row_decoder_chk u_chk (.*);

// File: tb/dram_row_decoder_tb.sv
module dram_row_decoder_tb;
    import dram_row_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [IDX_W-1:0]  cfg_addr = '0;
    logic [BND_W-1:0]  cfg_wdata = '0;
    logic [BND_W-1:0]  cfg_rdata;
    logic              lk_valid = 1'b0;
    logic [ADDR_W-1:0] lk_addr = '0;
    logic              rs_valid;
    logic [ROWS-1:0]   rs_sel;
    logic [IDX_W-1:0]  rs_row;
    logic              rs_hit;
    logic              rs_oor;
    logic [ADDR_W-1:0] rs_offset;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dram_row_decoder u_dut (.*);

    typedef struct packed {
        logic [30:0] a;
        logic        hit;
        logic [2:0]  row;
        logic [30:0] off;
    } vec_t;

    // layout A: row0 16M, row1 empty, row2 48M, row3 128M, row4 empty,
    // row5 512M, row6 zero -> 2G, row7 zero after 2G -> empty
    localparam vec_t VT [12] = '{
        '{31'h0000_0000, 1'b1, 3'd0, 31'h0000_0000},
        '{31'h00FF_FFFF, 1'b1, 3'd0, 31'h00FF_FFFF},
        '{31'h0100_0000, 1'b1, 3'd2, 31'h0000_0000},
        '{31'h02FF_FFFF, 1'b1, 3'd2, 31'h01FF_FFFF},
        '{31'h0300_0000, 1'b1, 3'd3, 31'h0000_0000},
        '{31'h0512_3456, 1'b1, 3'd3, 31'h0212_3456},
        '{31'h07FF_FFFF, 1'b1, 3'd3, 31'h04FF_FFFF},
        '{31'h0800_0000, 1'b1, 3'd5, 31'h0000_0000},
        '{31'h1FFF_FFFF, 1'b1, 3'd5, 31'h17FF_FFFF},
        '{31'h2000_0000, 1'b1, 3'd6, 31'h0000_0000},
        '{31'h4000_0000, 1'b1, 3'd6, 31'h2000_0000},
        '{31'h7FFF_FFFF, 1'b1, 3'd6, 31'h5FFF_FFFF}
    };

    task automatic wr(input int idx, input logic [7:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = IDX_W'(idx);
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic issue(input logic [30:0] a);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_addr  = a;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic check_rsp(input string tag, input logic hit, input logic [2:0] row,
                             input logic [30:0] off);
        logic [ROWS-1:0] esel;
        logic [2:0]      erow;
        logic [30:0]     eoff;
        esel = hit ? (ROWS'(1) << row) : '0;
        erow = hit ? row : 3'd0;
        eoff = hit ? off : 31'd0;
        n_chk++;
        if (rs_valid !== 1'b1 || rs_hit !== hit || rs_oor !== !hit ||
            rs_sel !== esel || rs_row !== erow || rs_offset !== eoff) begin
            n_bad++;
            $display("FAIL %s: got v=%0b hit=%0b oor=%0b sel=%h row=%0d off=%h exp hit=%0b sel=%h row=%0d off=%h",
                     tag, rs_valid, rs_hit, rs_oor, rs_sel, rs_row, rs_offset,
                     hit, esel, erow, eoff);
        end
    endtask

    task automatic look(input string tag, input logic [30:0] a, input logic hit,
                        input logic [2:0] row, input logic [30:0] off);
        issue(a);
        check_rsp(tag, hit, row, off);
    endtask

    task automatic check_rd(input string tag, input int idx, input logic [7:0] exp);
        cfg_addr = IDX_W'(idx);
        #1;
        n_chk++;
        if (cfg_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s: row %0d readback got %h exp %h", tag, idx, cfg_rdata, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, got hung exp done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] lay_a [8];
        lay_a = '{8'h02, 8'h02, 8'h06, 8'h10, 8'h10, 8'h40, 8'h00, 8'h00};

        repeat (3) @(negedge clk);
        // R1: reset state
        n_chk++;
        if (rs_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: rs_valid got %0b exp 0", rs_valid);
        end
        for (int i = 0; i < ROWS; i++) check_rd("R1", i, 8'h00);
        rst_n = 1'b1;
        look("R1", 31'h0000_0000, 1'b0, 3'd0, 31'd0);
        look("R1", 31'h4000_0000, 1'b0, 3'd0, 31'd0);

        // R2: program layout A and read it back
        for (int i = 0; i < ROWS; i++) wr(i, lay_a[i]);
        @(negedge clk);
        for (int i = 0; i < ROWS; i++) check_rd("R2", i, lay_a[i]);

        // R3 R4 R5: table walk (row1 and row4 empty, row6 zero -> 2G)
        for (int i = 0; i < 12; i++) begin
            look($sformatf("R3/R4/R5 vec %0d", i), VT[i].a, VT[i].hit, VT[i].row, VT[i].off);
        end

        // R8: idle edge keeps fields, drops valid
        @(negedge clk);
        lk_addr = 31'h0000_0010;
        @(negedge clk);
        n_chk++;
        if (rs_valid !== 1'b0 || rs_row !== 3'd6 || rs_offset !== 31'h5FFF_FFFF ||
            rs_sel !== 8'h40) begin
            n_bad++;
            $display("FAIL R8: idle got v=%0b row=%0d off=%h sel=%h exp v=0 row=6 off=5fffffff sel=40",
                     rs_valid, rs_row, rs_offset, rs_sel);
        end

        // R9: write row6 to 512M at the same edge as a lookup in row6
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = 3'd6;
        cfg_wdata = 8'h40;
        lk_valid  = 1'b1;
        lk_addr   = 31'h2000_0000;
        @(negedge clk);
        cfg_we   = 1'b0;
        lk_valid = 1'b0;
        check_rsp("R9 same-edge", 1'b1, 3'd6, 31'h0);
        // R5: row7 zero now follows 512M -> 2G
        look("R5 row7 top", 31'h2000_0000, 1'b1, 3'd7, 31'h0);
        look("R4 row6 empty", 31'h3000_0000, 1'b1, 3'd7, 31'h1000_0000);
        // R7: close the top at 512M
        wr(7, 8'h40);
        look("R7 above top", 31'h2000_0000, 1'b0, 3'd0, 31'd0);
        look("R7 far above", 31'h7FFF_FFFF, 1'b0, 3'd0, 31'd0);
        look("R3 below top", 31'h1FFF_FFFF, 1'b1, 3'd5, 31'h17FF_FFFF);

        // R6: overlapping windows, row0 [0,16M), row2 [8M,24M)
        wr(0, 8'h02);
        wr(1, 8'h01);
        wr(2, 8'h03);
        for (int i = 3; i < ROWS; i++) wr(i, 8'h03);
        look("R6 overlap", 31'h00A0_0000, 1'b1, 3'd0, 31'h00A0_0000);
        look("R6 upper part", 31'h0100_0000, 1'b1, 3'd2, 31'h0080_0000);
        look("R7 past 24M", 31'h0180_0000, 1'b0, 3'd0, 31'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule